// File: doc/BRIEF.md
# Vectored Interrupt Controller with Shared Peripheral Vector

This block sits beside a small processor core and turns peripheral events into vectored call requests. Each counter overflow (one per timer, plus a time base) owns its own request flag and its own vector. Three further sources share a single vector. These are an A/D end-of-conversion pulse, a serial byte-complete pulse and a falling edge on an external pin. They share it through a grouped request flag. Every source has an enable bit, and one global enable gates every call.

When the global enable is set, the core's return stack has room and at least one enabled request is pending, the block raises a one-cycle call request carrying a vector index. It then waits for the core's service acknowledge. The acknowledge clears the global enable and the serviced vector's own flag. For the shared vector, only the grouped flag is cleared and the three sub-source flags stay set until software clears them. A return strobe from the core, or a software write, sets the global enable again. Software writes flags, enables and the global enable through a set/clear port and can read them back.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: After reset the flag register, the enable register and the global enable are all 0, and the call request is low.
- R2: A one-cycle overflow pulse on a timer input or on the time base input sets the matching flag on the next clock edge. Flag bits 0..NUM_TIMERS-1 are the timers, bit NUM_TIMERS is the time base, and the same layout is used in the enable register.
- R3: A call request is a single-cycle pulse, raised one cycle after the global enable, a source enable and its flag are all seen high. Its vector index is the timer number for a timer, NUM_TIMERS for the time base and NUM_TIMERS+1 for the shared vector.
- R4: While the stack-full input is high, no call is issued and pending flags stay set. The call is issued on the cycle after stack-full drops.
- R5: When several enabled requests are pending, the lowest vector index wins: timers in order, then the time base, then the shared vector.
- R6: A service acknowledge for a dedicated vector clears that vector's flag and the global enable, and leaves every other flag unchanged.
- R7: The sub-source flags sit at bits NUM_TIMERS+2 (A/D), +3 (serial) and +4 (external). An event always sets its own sub-flag. The shared flag at bit NUM_TIMERS+1 is set only when the event arrives while that sub-source's enable bit is 1.
- R8: A service acknowledge for the shared vector clears the shared flag and the global enable but leaves the sub-source flags set. A software clear then removes them.
- R9: The external pin passes through two synchronising flops. A high-to-low transition sets the external flag exactly once, on the third clock edge after the pin falls. A pin that stays low or rises sets nothing more.
- R10: A hardware event that sets a flag in the same cycle as a software clear of that flag leaves the flag set. Other bits in the same clear are cleared.
- R11: The return strobe, or a software write to select 2 with mask bit 0 set, sets the global enable. Select 0 writes flags, select 1 writes enables, and regSet picks set (1) or clear (0) of the masked bits.
- R12: After a call request and until the acknowledge, no further call is raised and the vector index does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| timerOvf | input | NUM_TIMERS | Per-timer overflow pulses |
| tbOvf | input | 1 | Time base overflow pulse |
| adcDone | input | 1 | A/D conversion finished pulse |
| serDone | input | 1 | Serial byte sent or received pulse |
| extPin | input | 1 | External interrupt pin (asynchronous) |
| stackFull | input | 1 | Core return stack is full |
| svcAck | input | 1 | Core accepts the outstanding call |
| retiStrobe | input | 1 | Core returned from an interrupt routine |
| regWrEn | input | 1 | Software write strobe |
| regSel | input | 2 | Write target: 0 flags, 1 enables, 2 global enable |
| regSet | input | 1 | 1 sets masked bits, 0 clears them |
| regMask | input | NUM_TIMERS+5 | Bit mask of the write |
| callReq | output | 1 | One-cycle vectored call request |
| vecIdx | output | clog2(NUM_TIMERS+2) | Vector index of the call |
| flagsQ | output | NUM_TIMERS+5 | Request flag register |
| enablesQ | output | NUM_TIMERS+5 | Enable register |
| globalEn | output | 1 | Global interrupt enable |

## Verification
Two paths can hit the same flag bit in one cycle: a hardware event that sets it and a software write that clears it. The bench drives both together, first as a directed case where a neighbouring bit in the same mask must still clear. It then runs a long seeded random run in which timer overflow pulses and flag-clear writes land in arbitrary combinations. After every edge, each timer flag is compared with a model in which the set always wins. Service clearing and the return strobe likewise meet the global enable, and the check there only passes if the acknowledge's clear takes effect as stated.

// File: rtl/mcu_irq_pkg.sv
package mcu_irq_pkg;
  localparam int NUM_TIMERS  = 2;
  localparam int NUM_VEC     = NUM_TIMERS + 2;
  localparam int VEC_W       = $clog2(NUM_VEC);
  localparam int TB_BIT      = NUM_TIMERS;
  localparam int MF_BIT      = NUM_TIMERS + 1;
  localparam int ADC_BIT     = NUM_TIMERS + 2;
  localparam int SER_BIT     = NUM_TIMERS + 3;
  localparam int EXT_BIT     = NUM_TIMERS + 4;
  localparam int REG_W       = NUM_TIMERS + 5;
  localparam int SYNC_STAGES = 2;

  localparam logic [1:0] SEL_FLAG = 2'd0;
  localparam logic [1:0] SEL_EN   = 2'd1;
  localparam logic [1:0] SEL_GLB  = 2'd2;

  typedef struct packed {
    logic               svcClr;
    logic [NUM_VEC-1:0] clrVec;
  } ctlStrobe_t;

  typedef enum logic [0:0] {ST_IDLE, ST_WAIT} callState_t;
endpackage

// File: rtl/mcu_irq_fall_detect.sv
module mcu_irq_fall_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pinIn,
  output logic fallPulse
);
  // shiftQ[STAGES-1] is the synchronised pin, shiftQ[STAGES] its last value
  logic [STAGES:0] shiftQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shiftQ <= '1;
    else        shiftQ <= {shiftQ[STAGES-1:0], pinIn};
  end

  assign fallPulse = shiftQ[STAGES] & ~shiftQ[STAGES-1];
endmodule

// File: rtl/mcu_irq_datapath.sv
module mcu_irq_datapath
  import mcu_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_TIMERS-1:0] timerOvf,
  input  logic                  tbOvf,
  input  logic                  adcDone,
  input  logic                  serDone,
  input  logic                  extFall,
  input  logic                  regWrEn,
  input  logic [1:0]            regSel,
  input  logic                  regSet,
  input  logic [REG_W-1:0]      regMask,
  input  logic                  retiStrobe,
  input  ctlStrobe_t            ctl,
  output logic [REG_W-1:0]      flagsQ,
  output logic [REG_W-1:0]      enablesQ,
  output logic                  globalEn,
  output logic [NUM_VEC-1:0]    pendVec
);
  logic [REG_W-1:0] hwSet, hwClr;
  logic [REG_W-1:0] swFlagSet, swFlagClr, swEnSet, swEnClr;
  logic [2:0]       subEvent, subEn;
  logic             glbSet, glbClr;

  assign subEvent = {extFall, serDone, adcDone};
  assign subEn    = enablesQ[EXT_BIT:ADC_BIT];

  always_comb begin
    hwSet                   = '0;
    hwSet[NUM_TIMERS-1:0]   = timerOvf;
    hwSet[TB_BIT]           = tbOvf;
    hwSet[ADC_BIT]          = adcDone;
    hwSet[SER_BIT]          = serDone;
    hwSet[EXT_BIT]          = extFall;
    hwSet[MF_BIT]           = |(subEvent & subEn);
    hwClr                   = '0;
    hwClr[NUM_VEC-1:0]      = ctl.svcClr ? ctl.clrVec : '0;
  end

  always_comb begin
    swFlagSet = '0;
    swFlagClr = '0;
    swEnSet   = '0;
    swEnClr   = '0;
    glbSet    = retiStrobe;
    glbClr    = ctl.svcClr;
    if (regWrEn) begin
      unique case (regSel)
        SEL_FLAG: if (regSet) swFlagSet = regMask; else swFlagClr = regMask;
        SEL_EN:   if (regSet) swEnSet   = regMask; else swEnClr   = regMask;
        SEL_GLB:  if (regSet) glbSet = glbSet | regMask[0];
                  else        glbClr = glbClr | regMask[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flagsQ   <= '0;
      enablesQ <= '0;
      globalEn <= 1'b0;
    end else begin
      // sets are applied last so an event never loses to a clear
      flagsQ   <= (flagsQ & ~swFlagClr & ~hwClr) | swFlagSet | hwSet;
      enablesQ <= (enablesQ & ~swEnClr) | swEnSet;
      globalEn <= (globalEn & ~glbClr) | glbSet;
    end
  end

  assign pendVec = flagsQ[NUM_VEC-1:0] & enablesQ[NUM_VEC-1:0];
endmodule

// File: rtl/mcu_irq_control.sv
module mcu_irq_control
  import mcu_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_VEC-1:0] pendVec,
  input  logic               globalEn,
  input  logic               stackFull,
  input  logic               svcAck,
  output logic               callReq,
  output logic [VEC_W-1:0]   vecIdx,
  output ctlStrobe_t         ctl
);
  callState_t       stateQ;
  logic [VEC_W-1:0] pickIdx;
  logic             canCall;

  always_comb begin
    pickIdx = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (pendVec[i]) pickIdx = VEC_W'(i);
    end
  end

  assign canCall = (stateQ == ST_IDLE) && globalEn && !stackFull && (|pendVec);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stateQ  <= ST_IDLE;
      callReq <= 1'b0;
      vecIdx  <= '0;
    end else begin
      callReq <= canCall;
      unique case (stateQ)
        ST_IDLE: if (canCall) begin
          vecIdx <= pickIdx;
          stateQ <= ST_WAIT;
        end
        ST_WAIT: if (svcAck) stateQ <= ST_IDLE;
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  assign ctl.svcClr = (stateQ == ST_WAIT) && svcAck;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_clr
    assign ctl.clrVec[v] = (vecIdx == VEC_W'(v));
  end
endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl
  import mcu_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_TIMERS-1:0] timerOvf,
  input  logic                  tbOvf,
  input  logic                  adcDone,
  input  logic                  serDone,
  input  logic                  extPin,
  input  logic                  stackFull,
  input  logic                  svcAck,
  input  logic                  retiStrobe,
  input  logic                  regWrEn,
  input  logic [1:0]            regSel,
  input  logic                  regSet,
  input  logic [REG_W-1:0]      regMask,
  output logic                  callReq,
  output logic [VEC_W-1:0]      vecIdx,
  output logic [REG_W-1:0]      flagsQ,
  output logic [REG_W-1:0]      enablesQ,
  output logic                  globalEn
);
  logic               extFall;
  logic [NUM_VEC-1:0] pendVec;
  ctlStrobe_t         ctl;

  mcu_irq_fall_detect #(.STAGES(SYNC_STAGES)) i_fall (
    .clk(clk), .rst_n(rst_n), .pinIn(extPin), .fallPulse(extFall)
  );

  mcu_irq_datapath i_dp (
    .clk(clk), .rst_n(rst_n), .timerOvf(timerOvf), .tbOvf(tbOvf),
    .adcDone(adcDone), .serDone(serDone), .extFall(extFall),
    .regWrEn(regWrEn), .regSel(regSel), .regSet(regSet), .regMask(regMask),
    .retiStrobe(retiStrobe), .ctl(ctl), .flagsQ(flagsQ), .enablesQ(enablesQ),
    .globalEn(globalEn), .pendVec(pendVec)
  );

  mcu_irq_control i_ctl (
    .clk(clk), .rst_n(rst_n), .pendVec(pendVec), .globalEn(globalEn),
    .stackFull(stackFull), .svcAck(svcAck), .callReq(callReq),
    .vecIdx(vecIdx), .ctl(ctl)
  );
endmodule

// File: rtl/mcu_irq_checker.sv
module mcu_irq_checker
  import mcu_irq_pkg::*;
(
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_TIMERS-1:0] timerOvf,
  input logic                  stackFull,
  input logic                  svcAck,
  input logic                  retiStrobe,
  input logic                  regWrEn,
  input logic [1:0]            regSel,
  input logic                  regSet,
  input logic                  callReq,
  input logic [VEC_W-1:0]      vecIdx,
  input logic [REG_W-1:0]      flagsQ,
  input logic                  globalEn
);
  logic outstanding, waiting, glbWrSet;

  assign waiting  = outstanding | callReq;
  assign glbWrSet = regWrEn && (regSel == SEL_GLB) && regSet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outstanding <= 1'b0;
    else        outstanding <= waiting & ~svcAck;
  end

  assert_call_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    callReq |=> !callReq);
  assert_call_needs_global_R3: assert property (@(posedge clk) disable iff (!rst_n)
    callReq |-> $past(globalEn));
  assert_vec_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    callReq |-> (int'(vecIdx) < NUM_VEC));
  assert_stack_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    callReq |-> !$past(stackFull));
  assert_ack_drops_global_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && svcAck && !retiStrobe && !glbWrSet) |=> !globalEn);
  assert_one_call_R12: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !callReq);
  assert_vec_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !svcAck) |=> $stable(vecIdx));

  for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
    assert_event_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      timerOvf[t] |=> flagsQ[t]);
  end
endmodule

bind mcu_irq_ctrl mcu_irq_checker i_chk (
  .clk(clk), .rst_n(rst_n), .timerOvf(timerOvf), .stackFull(stackFull),
  .svcAck(svcAck), .retiStrobe(retiStrobe), .regWrEn(regWrEn),
  .regSel(regSel), .regSet(regSet), .callReq(callReq), .vecIdx(vecIdx),
  .flagsQ(flagsQ), .globalEn(globalEn)
);

// File: tb/test_mcu_irq_ctrl.sv
`timescale 1ns/1ps
module test_mcu_irq_ctrl;
  import mcu_irq_pkg::*;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic [NUM_TIMERS-1:0] timerOvf;
  logic                  tbOvf, adcDone, serDone, extPin, stackFull;
  logic                  svcAck, retiStrobe, regWrEn, regSet;
  logic [1:0]            regSel;
  logic [REG_W-1:0]      regMask;
  logic                  callReq, globalEn;
  logic [VEC_W-1:0]      vecIdx;
  logic [REG_W-1:0]      flagsQ, enablesQ;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  mcu_irq_ctrl i_mcu_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .timerOvf(timerOvf), .tbOvf(tbOvf),
    .adcDone(adcDone), .serDone(serDone), .extPin(extPin),
    .stackFull(stackFull), .svcAck(svcAck), .retiStrobe(retiStrobe),
    .regWrEn(regWrEn), .regSel(regSel), .regSet(regSet), .regMask(regMask),
    .callReq(callReq), .vecIdx(vecIdx), .flagsQ(flagsQ),
    .enablesQ(enablesQ), .globalEn(globalEn)
  );

  function automatic logic [REG_W-1:0] bitMask(int n);
    bitMask = '0;
    bitMask[n] = 1'b1;
  endfunction

  function automatic logic [NUM_TIMERS-1:0] modelTimers(
      logic [NUM_TIMERS-1:0] prev, logic [NUM_TIMERS-1:0] clr, logic [NUM_TIMERS-1:0] ev);
    modelTimers = (prev & ~clr) | ev;
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic swWrite(logic [1:0] sel, logic setOp, logic [REG_W-1:0] mask);
    regWrEn = 1'b1; regSel = sel; regSet = setOp; regMask = mask;
    tick();
    regWrEn = 1'b0; regMask = '0;
  endtask

  task automatic pulseTimer(int n);
    timerOvf[n] = 1'b1;
    tick();
    timerOvf = '0;
  endtask

  task automatic ackCall();
    svcAck = 1'b1;
    tick();
    svcAck = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [NUM_TIMERS-1:0] expT;
    logic [31:0]           rnd;
    logic [NUM_TIMERS-1:0] ev, clr;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; timerOvf = '0; tbOvf = 0; adcDone = 0; serDone = 0;
    extPin = 1'b1; stackFull = 0; svcAck = 0; retiStrobe = 0;
    regWrEn = 0; regSel = '0; regSet = 0; regMask = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    check("R1 flags", flagsQ, 0);
    check("R1 enables", enablesQ, 0);
    check("R1 global", globalEn, 0);
    check("R1 call", callReq, 0);

    // R2 overflow sets flags; nothing enabled so no call
    pulseTimer(1);
    check("R2 timer1 flag", flagsQ, bitMask(1));
    tbOvf = 1; tick(); tbOvf = 0;
    check("R2 timebase flag", flagsQ, bitMask(1) | bitMask(TB_BIT));
    repeat (2) tick();
    check("R3 no call when disabled", callReq, 0);
    swWrite(SEL_FLAG, 1'b0, '1);
    check("R11 flag clear write", flagsQ, 0);

    // R3 basic call, R12 hold, R6 acknowledge
    swWrite(SEL_EN, 1'b1, bitMask(0));
    swWrite(SEL_GLB, 1'b1, 1);
    check("R11 global set write", globalEn, 1);
    pulseTimer(0);
    check("R3 call not yet", callReq, 0);
    tick();
    check("R3 call raised", callReq, 1);
    check("R3 vector timer0", vecIdx, 0);
    tick();
    check("R3 call is one pulse", callReq, 0);
    pulseTimer(1);
    repeat (2) tick();
    check("R12 no second call", callReq, 0);
    check("R12 vector held", vecIdx, 0);
    ackCall();
    check("R6 serviced flag cleared", flagsQ, bitMask(1));
    check("R6 global cleared", globalEn, 0);
    swWrite(SEL_FLAG, 1'b0, bitMask(1));

    // R11 return strobe re-enables
    retiStrobe = 1; tick(); retiStrobe = 0;
    check("R11 return strobe", globalEn, 1);

    // R4 stack full blocks
    stackFull = 1'b1;
    pulseTimer(0);
    for (int k = 0; k < 4; k++) begin
      tick();
      check("R4 blocked while full", callReq, 0);
    end
    check("R4 flag kept", flagsQ, bitMask(0));
    stackFull = 1'b0;
    tick();
    check("R4 call after stack frees", callReq, 1);
    check("R4 vector", vecIdx, 0);
    ackCall();

    // R5 priority
    swWrite(SEL_EN, 1'b1, bitMask(1) | bitMask(TB_BIT) | bitMask(MF_BIT));
    swWrite(SEL_FLAG, 1'b1, bitMask(1) | bitMask(TB_BIT));
    swWrite(SEL_GLB, 1'b1, 1);
    tick();
    check("R5 timer1 before time base", callReq, 1);
    check("R5 vector timer1", vecIdx, 1);
    ackCall();
    check("R6 others untouched", flagsQ, bitMask(TB_BIT));
    swWrite(SEL_GLB, 1'b1, 1);
    tick();
    check("R5 time base next", callReq, 1);
    check("R5 vector time base", vecIdx, TB_BIT);
    ackCall();
    check("R6 time base flag cleared", flagsQ, 0);

    // R7 / R8 shared vector
    swWrite(SEL_EN, 1'b1, bitMask(ADC_BIT));
    serDone = 1; tick(); serDone = 0;
    check("R7 serial flag only", flagsQ, bitMask(SER_BIT));
    adcDone = 1; tick(); adcDone = 0;
    check("R7 adc sets shared flag", flagsQ,
          bitMask(SER_BIT) | bitMask(ADC_BIT) | bitMask(MF_BIT));
    swWrite(SEL_GLB, 1'b1, 1);
    tick();
    check("R8 shared call", callReq, 1);
    check("R8 shared vector", vecIdx, MF_BIT);
    ackCall();
    check("R8 sub flags stay", flagsQ, bitMask(SER_BIT) | bitMask(ADC_BIT));
    check("R8 global cleared", globalEn, 0);
    swWrite(SEL_FLAG, 1'b0, bitMask(SER_BIT) | bitMask(ADC_BIT));
    check("R8 software clears sub flags", flagsQ, 0);

    // R9 external pin
    extPin = 1'b0;
    tick();
    check("R9 edge 1", flagsQ, 0);
    tick();
    check("R9 edge 2", flagsQ, 0);
    tick();
    check("R9 edge 3 sets", flagsQ, bitMask(EXT_BIT));
    swWrite(SEL_FLAG, 1'b0, bitMask(EXT_BIT));
    repeat (4) tick();
    check("R9 steady low once", flagsQ, 0);
    extPin = 1'b1;
    repeat (5) tick();
    check("R9 rise ignored", flagsQ, 0);

    // R10 directed collision
    swWrite(SEL_FLAG, 1'b1, bitMask(0) | bitMask(1));
    timerOvf[1] = 1'b1;
    swWrite(SEL_FLAG, 1'b0, bitMask(0) | bitMask(1));
    timerOvf = '0;
    check("R10 event beats clear", flagsQ, bitMask(1));

    // R10 random collisions, nothing enabled
    swWrite(SEL_EN, 1'b0, '1);
    swWrite(SEL_FLAG, 1'b0, '1);
    expT = '0;
    for (int n = 0; n < 400; n++) begin
      rnd = $urandom;
      ev  = rnd[NUM_TIMERS-1:0] & {NUM_TIMERS{rnd[8]}};
      clr = rnd[NUM_TIMERS+3:4] & {NUM_TIMERS{rnd[9]}};
      timerOvf = ev;
      regWrEn  = |clr; regSel = SEL_FLAG; regSet = 1'b0;
      regMask  = '0; regMask[NUM_TIMERS-1:0] = clr;
      expT = modelTimers(expT, clr, ev);
      tick();
      check("R10 random timer flags", flagsQ[NUM_TIMERS-1:0], expT);
      check("R3 random no call", callReq, 0);
    end
    timerOvf = '0; regWrEn = 1'b0; regMask = '0;
    tick();
    finishRun();
  end
endmodule